// File: doc/BRIEF.md
# GPIO Interrupt Detect and Aggregate Unit

This unit watches 94 already-synchronized general-purpose input pins. For each pin it can detect one of four kinds of event: a rising edge, a falling edge, a low level or a high level. Two configuration bits per pin select the kind. When a detected event belongs to a pin that is enabled and has input sensing turned on, a sticky status bit is set. Status bits are grouped into 32-bit words. Software reads them and clears them by writing ones.

The status is masked with per-pin enable bits and reduced to a single registered interrupt line shared by all pins. A small register port gives access to the status and enable words. Writes to status words clear the selected bits. Writes to enable words replace the whole word. Reads return a registered word one cycle after the address is presented.

Top module: `gpio_irq_agg`

## Requirements
- R1: The pair {trig_level, trig_inv} of a pin selects its event kind: 00 rising edge (pin 1 now, 0 at the previous clock), 01 falling edge, 10 level low, 11 level high. A detected event sets the status bit at the clock edge where it is sampled.
- R2: A status bit is set only when the pin's enable bit and its sense_en input are both 1. Otherwise the pin never sets status.
- R3: A write to a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set. A level event therefore re-sets its bit on every cycle while the level persists.
- R5: An edge arriving in the cycle right after its bit was cleared sets the bit again.
- R6: irq is a register holding the OR of (status AND enable) over all pins. It rises one cycle after a pending bit appears and falls one cycle after the last pending bit is cleared or disabled. Clearing an enable bit leaves its status bit unchanged.
- R7: Address bit 2 selects status words (0) or enable words (1). Address bits 1:0 select word k, whose bit b belongs to pin 32k+b. Word index 3 reads as zero. rdata holds the addressed word one cycle after the address is applied.
- R8: Reset (synchronous, active high) clears all status bits, all enable bits and irq.
- R9: Bits 30 and 31 of word 2 have no pin behind them. They read as zero in both status and enable words, and writes to them have no effect.
- R10: A write to an enable word loads all bits of that word from wdata. The other enable words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 94 | Synchronized pin levels |
| trig_level | input | 94 | Per pin: 0 edge trigger, 1 level trigger |
| trig_inv | input | 94 | Per pin: selects falling edge / high level when 1 |
| sense_en | input | 94 | Per pin input sensing enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Shared interrupt output |

## Verification
A wrongly set or cleared status bit shows on irq one cycle later, as long as its pin is enabled. It also shows in rdata one cycle after its word is addressed, whether or not the pin is enabled. A fault in edge memory (the previous-pin register) or in the trigger decode shows up as a missing or extra status bit after a single pin transition. A fault in the clear logic shows up as a wrong neighbour bit, or as a lost event, in the word read straight after a write. Faults in the enable path are separated from faults in the status path by reading status with the pin disabled while watching irq stay low.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  // {trig_level, trig_inv}
  typedef enum logic [1:0] {
    TRG_RISE = 2'b00,
    TRG_FALL = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trig_kind_e;

  function automatic int words_for(input int pins, input int width);
    return (pins + width - 1) / width;
  endfunction

  function automatic int idx_bits(input int words);
    return (words <= 1) ? 1 : $clog2(words);
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 94
) (
  input  logic                clk,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] sense_en,
  output logic [NUM_PINS-1:0] evt
);

  // pin value seen at the previous clock, for edge detection
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= pin_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    always_comb begin
      unique case (trig_kind_e'({trig_level[i], trig_inv[i]}))
        TRG_RISE: hit = pin_in[i] & ~prev_q[i];
        TRG_FALL: hit = ~pin_in[i] & prev_q[i];
        TRG_LOW:  hit = ~pin_in[i];
        default:  hit = pin_in[i];
      endcase
    end
    assign evt[i] = sense_en[i] & hit;
  end

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs #(
  parameter int NUM_PINS = 94
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] set_v,
  input  logic [NUM_PINS-1:0] clr_v,
  input  logic [NUM_PINS-1:0] en_ld,
  input  logic [NUM_PINS-1:0] en_val,
  output logic [NUM_PINS-1:0] st_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic                irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      // set has priority over clear so no event is lost
      st_q <= (st_q & ~clr_v) | set_v;
      en_q <= (en_q & ~en_ld) | (en_val & en_ld);
      irq  <= |(st_q & en_q);
    end
  end

endmodule

// File: rtl/gpio_irq_bus.sv
`timescale 1ns/1ps
module gpio_irq_bus
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = words_for(NUM_PINS, WORD_W),
  localparam int IDX_W   = idx_bits(NWORDS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int PAD_W   = NWORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] st_q,
  input  logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] clr_v,
  output logic [NUM_PINS-1:0] en_ld,
  output logic [NUM_PINS-1:0] en_val,
  output logic [WORD_W-1:0]   rdata
);

  logic              sel_en;
  logic [IDX_W-1:0]  widx;
  logic [PAD_W-1:0]  st_pad;
  logic [PAD_W-1:0]  en_pad;
  logic [WORD_W-1:0] rd_word;

  assign sel_en = addr[ADDR_W-1];
  assign widx   = addr[IDX_W-1:0];
  assign st_pad = PAD_W'(st_q);
  assign en_pad = PAD_W'(en_q);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    logic hit_word;
    assign hit_word = wr_en && (widx == IDX_W'(i / WORD_W));
    assign clr_v[i]  = hit_word && !sel_en && wdata[i % WORD_W];
    assign en_ld[i]  = hit_word && sel_en;
    assign en_val[i] = wdata[i % WORD_W];
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (widx == IDX_W'(w)) begin
        rd_word = sel_en ? en_pad[w*WORD_W +: WORD_W] : st_pad[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

endmodule

// File: rtl/gpio_irq_agg.sv
`timescale 1ns/1ps
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = words_for(NUM_PINS, WORD_W),
  localparam int IDX_W   = idx_bits(NWORDS),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                irq
);

  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] set_v;
  logic [NUM_PINS-1:0] clr_v;
  logic [NUM_PINS-1:0] en_ld;
  logic [NUM_PINS-1:0] en_val;
  logic [NUM_PINS-1:0] st_q;
  logic [NUM_PINS-1:0] en_q;

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk        (clk),
    .pin_in     (pin_in),
    .trig_level (trig_level),
    .trig_inv   (trig_inv),
    .sense_en   (sense_en),
    .evt        (evt)
  );

  // only enabled pins may latch status
  assign set_v = evt & en_q;

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .en_ld  (en_ld),
    .en_val (en_val),
    .st_q   (st_q),
    .en_q   (en_q),
    .irq    (irq)
  );

  gpio_irq_bus #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .st_q   (st_q),
    .en_q   (en_q),
    .clr_v  (clr_v),
    .en_ld  (en_ld),
    .en_val (en_val),
    .rdata  (rdata)
  );

endmodule

// File: rtl/gpio_irq_agg_chk.sv
`timescale 1ns/1ps
module gpio_irq_agg_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 94,
  parameter int WORD_W   = 32,
  localparam int NWORDS  = words_for(NUM_PINS, WORD_W),
  localparam int IDX_W   = idx_bits(NWORDS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int PADB    = NWORDS * WORD_W - NUM_PINS
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] st_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] set_v,
  input logic [NUM_PINS-1:0] clr_v,
  input logic                irq,
  input logic [ADDR_W-1:0]   addr,
  input logic [WORD_W-1:0]   rdata
);

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (st_q & ~$past(st_q) & ~$past(en_q)) == '0); // R2

  AST_SET_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    (st_q & ~$past(st_q) & ~$past(set_v)) == '0); // R2

  AST_DROP_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (~st_q & $past(st_q) & ~$past(clr_v)) == '0); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(set_v) & ~st_q) == '0); // R4

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(st_q & en_q))); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $fell(rst) |-> (st_q == '0 && en_q == '0 && !irq)); // R8

  if (PADB > 0) begin : g_pad
    localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_W) - 1);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NWORDS - 1);
    localparam logic [WORD_W-1:0] PAD_MASK = {WORD_W{1'b1}} << (WORD_W - PADB);
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (($past(addr) & IDX_MASK) == LAST_IDX) |-> ((rdata & PAD_MASK) == '0)); // R9
  end

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .st_q  (st_q),
  .en_q  (en_q),
  .set_v (set_v),
  .clr_v (clr_v),
  .irq   (irq),
  .addr  (addr),
  .rdata (rdata)
);

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb;

  localparam int NP = 94;
  localparam int NV = 12;
  localparam int WDOG_NS = 200000 * 4;

  // {pin[6:0], level, inv, p0, p1, p2, expected}
  localparam logic [12:0] VEC [NV] = '{
    {7'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {7'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'd31, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'd32, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'd40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {7'd63, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd64, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'd93, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'd70, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'd50, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'd88, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] trig_level = '0;
  logic [NP-1:0] trig_inv = '0;
  logic [NP-1:0] sense_en = '1;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_agg u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .trig_level(trig_level),
    .trig_inv(trig_inv), .sense_en(sense_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic clear_all();
    bus_wr(3'd0, '1); bus_wr(3'd1, '1); bus_wr(3'd2, '1);
  endtask

  initial begin
    #(WDOG_NS);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R8 reset state, R7 all addresses including unused index
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), rd);
      check("R8 R7 reset word", rd, 32'h0);
    end
    check("R8 reset irq", {31'b0, irq}, 32'h0);

    // enable every pin, R10
    bus_wr(3'd4, '1); bus_wr(3'd5, '1); bus_wr(3'd6, '1);

    // table walk: R1 trigger decode, R7 mapping, R6 irq
    for (int v = 0; v < NV; v++) begin
      logic [6:0] pn;
      logic lv, iv, p0, p1, p2, ex;
      {pn, lv, iv, p0, p1, p2, ex} = VEC[v];
      trig_level[pn] = lv; trig_inv[pn] = iv; pin_in[pn] = p0;
      tick(2);
      clear_all();
      pin_in[pn] = p1; tick(1);
      pin_in[pn] = p2; tick(1);
      bus_rd(3'(pn / 32), rd);
      check($sformatf("R1 R7 vector %0d", v), rd, 32'(ex) << (pn % 32));
      check($sformatf("R6 vector %0d irq", v), {31'b0, irq}, {31'b0, ex});
      pin_in[pn] = 1'b0; trig_level[pn] = 1'b0; trig_inv[pn] = 1'b0;
      tick(1);
    end
    clear_all();
    tick(1);

    // R3: clear only written ones
    pin_in[3] = 1'b1; pin_in[4] = 1'b1; tick(1);
    pin_in[3] = 1'b0; pin_in[4] = 1'b0; tick(1);
    bus_wr(3'd0, 32'h8);
    bus_rd(3'd0, rd);
    check("R3 clear one bit", rd, 32'h10);
    bus_wr(3'd0, 32'h0);
    bus_rd(3'd0, rd);
    check("R3 zero write no effect", rd, 32'h10);

    // R6 irq fall timing: still high right after clear edge, low one later
    check("R6 irq pending", {31'b0, irq}, 32'h1);
    bus_wr(3'd0, 32'h10);
    check("R6 irq one cycle after clear", {31'b0, irq}, 32'h1);
    tick(1);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);

    // R6 irq rise timing
    pin_in[4] = 1'b1; tick(1);
    check("R6 irq not yet", {31'b0, irq}, 32'h0);
    tick(1);
    check("R6 irq raised", {31'b0, irq}, 32'h1);
    pin_in[4] = 1'b0;
    bus_wr(3'd0, 32'h10); tick(1);

    // R2 enable gating
    bus_wr(3'd4, ~32'h80);
    pin_in[7] = 1'b1; tick(2);
    bus_rd(3'd0, rd);
    check("R2 disabled pin no status", rd, 32'h0);
    check("R2 disabled pin no irq", {31'b0, irq}, 32'h0);
    pin_in[7] = 1'b0;
    bus_wr(3'd4, '1);

    // R2 sensing off
    sense_en[8] = 1'b0;
    pin_in[8] = 1'b1; tick(2);
    bus_rd(3'd0, rd);
    check("R2 sense off no status", rd, 32'h0);
    pin_in[8] = 1'b0; sense_en[8] = 1'b1; tick(1);

    // R6 masking keeps status
    pin_in[9] = 1'b1; tick(2);
    check("R6 irq from pin 9", {31'b0, irq}, 32'h1);
    pin_in[9] = 1'b0;
    bus_wr(3'd4, ~32'h200);
    bus_rd(3'd0, rd);
    check("R6 status kept when disabled", rd, 32'h200);
    check("R6 irq masked", {31'b0, irq}, 32'h0);
    bus_wr(3'd4, '1);
    bus_wr(3'd0, 32'h200);

    // R4 edge and clear in the same cycle
    pin_in[10] = 1'b1; tick(1);
    pin_in[10] = 1'b0; tick(1);
    pin_in[10] = 1'b1;
    bus_wr(3'd0, 32'h400);
    bus_rd(3'd0, rd);
    check("R4 event beats clear", rd, 32'h400);
    pin_in[10] = 1'b0;
    bus_wr(3'd0, 32'h400);

    // R4 level keeps re-setting
    trig_level[11] = 1'b1; trig_inv[11] = 1'b1; tick(1);
    pin_in[11] = 1'b1; tick(2);
    bus_wr(3'd0, 32'h800);
    bus_rd(3'd0, rd);
    check("R4 level survives clear", rd, 32'h800);
    pin_in[11] = 1'b0; tick(1);
    bus_wr(3'd0, 32'h800);
    bus_rd(3'd0, rd);
    check("R4 clear after level gone", rd, 32'h0);
    trig_level[11] = 1'b0; trig_inv[11] = 1'b0;

    // R5 edge right after clear
    pin_in[12] = 1'b1; tick(1);
    pin_in[12] = 1'b0; tick(1);
    bus_wr(3'd0, 32'h1000);
    pin_in[12] = 1'b1; tick(1);
    bus_rd(3'd0, rd);
    check("R5 edge after clear captured", rd, 32'h1000);
    pin_in[12] = 1'b0;
    clear_all();

    // R9 R10 padding and full-word enable load
    bus_wr(3'd5, 32'h0F0F_0F0F);
    bus_rd(3'd6, rd);
    check("R9 enable word 2 padding", rd, 32'h3FFF_FFFF);
    bus_rd(3'd5, rd);
    check("R10 enable word 1 loaded", rd, 32'h0F0F_0F0F);
    bus_rd(3'd4, rd);
    check("R10 enable word 0 untouched", rd, 32'hFFFF_FFFF);
    pin_in[93] = 1'b1; tick(1);
    bus_rd(3'd2, rd);
    check("R9 status word 2 padding", rd, 32'h2000_0000);
    bus_rd(3'd7, rd);
    check("R7 enable index 3 zero", rd, 32'h0);
    pin_in[93] = 1'b0;

    // R8 reset mid-run
    pin_in[20] = 1'b1; tick(2);
    pin_in[20] = 1'b0;
    rst = 1'b1; tick(2); rst = 1'b0;
    bus_rd(3'd0, rd);
    check("R8 status cleared", rd, 32'h0);
    bus_rd(3'd4, rd);
    check("R8 enable cleared", rd, 32'h0);
    check("R8 irq cleared", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule